// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block resolves the operand of one instruction. It takes a 4-bit addressing-mode code, an address field, the next-instruction program counter and a register selector. From these it produces the effective address and the operand value. It reads the general registers through a combinational read port owned by the surrounding datapath. It reaches memory through a single synchronous read port: an address and request are issued in one cycle, and the data is returned in the following cycle.

A single sequencer covers nine addressing modes. Some modes need no memory read, some need one, and indirect mode needs a pointer read followed by an operand read. The auto-increment mode returns a register write-back on the cycle of the done strobe. A caller pulses `start_i` while `busy_o` is low. It then waits for the one-cycle `done_o` pulse and uses `ea_o`, `operand_o`, `implied_o` and the write-back port on that cycle. The results stay unchanged until the next accepted start.

Top module: `ea_gen`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mem_req_o`, `wb_en_o` and `implied_o` are low, and `ea_o` and `operand_o` are zero.
- R2: Immediate mode (code 1) gives an operand equal to the zero-extended address field and an `ea_o` of zero. It makes no memory request, and `done_o` rises in the cycle after the start is accepted.
- R3: Register mode (code 2) gives an operand equal to the content of the register picked by `reg_sel_i`. It gives an `ea_o` of zero, makes no memory request and has one-cycle latency.
- R4: Register-indirect mode (code 3) uses the selected register's content as `ea_o`. It makes exactly one memory read at that address and returns the read word as the operand, with `done_o` three cycles after acceptance.
- R5: Auto-increment mode (code 4) behaves like R4. In addition, on the `done_o` cycle only, it raises `wb_en_o` with `wb_idx_o` equal to the selector and `wb_data_o` equal to the pre-increment register value plus one, wrapping modulo 2^AW.
- R6: Direct mode (code 5) uses the zero-extended field as `ea_o` and makes one read there, with three-cycle latency.
- R7: Indirect mode (code 6) first reads memory at the zero-extended field. The returned word becomes `ea_o`. A second read at that address supplies the operand, so there are exactly two reads, never on adjacent cycles, and `done_o` comes five cycles after acceptance.
- R8: Relative mode (code 7) forms `ea_o` as `pc_i` plus the field sign-extended from FW bits, modulo 2^AW. For example, field 500 with PC 252 gives 752. It makes one read, with three-cycle latency.
- R9: Indexed mode (code 8) forms `ea_o` as the zero-extended field plus the selected register's content, modulo 2^AW. It makes one read, with three-cycle latency.
- R10: Implied mode (code 0), and every unassigned code from 9 to 15, completes in one cycle with `implied_o` high, `ea_o` and `operand_o` zero, and no memory read.
- R11: `done_o` is a single-cycle pulse. A start presented while `busy_o` is high, including the `done_o` cycle itself, is ignored. Results hold after `done_o` until the next accepted start.
- R12: `wb_en_o` is never high outside the `done_o` cycle of an auto-increment operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin resolving one instruction (accepted when idle) |
| mode_i | input | 4 | Addressing-mode code |
| field_i | input | FW | Instruction address field |
| reg_sel_i | input | RW | Register selector (pointer, operand or index register) |
| pc_i | input | AW | Address of the next instruction |
| rf_raddr_o | output | RW | Register file read address |
| rf_rdata_i | input | DW | Register file read data, same cycle |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read address |
| mem_rdata_i | input | DW | Memory read data, one cycle after the request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| implied_o | output | 1 | Operand is implied; no address produced |
| ea_o | output | AW | Effective address |
| operand_o | output | DW | Operand value |
| wb_en_o | output | 1 | Register write-back enable (auto-increment) |
| wb_idx_o | output | RW | Register write-back index |
| wb_data_o | output | DW | Register write-back value |

## Verification
Counted from the clock edge that accepts the start, `done_o` is due after one cycle for the implied, immediate and register modes. It is due after three cycles for the single-read modes and after five for indirect mode. Each operation's expected latency is computed before it is launched. The bench then counts falling edges until `done_o` is seen and compares that count with the expected value. It also records every memory request observed on those falling edges, so the number and the addresses of the reads are checked alongside the values sampled on the done cycle. One falling edge after done, it checks that the strobe has dropped and that the address still holds.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_IMPLIED = 4'd0,
    AM_IMM     = 4'd1,
    AM_REG     = 4'd2,
    AM_RIND    = 4'd3,
    AM_RINC    = 4'd4,
    AM_DIR     = 4'd5,
    AM_IND     = 4'd6,
    AM_REL     = 4'd7,
    AM_IDX     = 4'd8
  } am_e;

  typedef struct packed {
    logic implied;
    logic use_mem;
    logic two_reads;
    logic wb;
    logic src_imm;
  } am_ctl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_PTR,
    S_WT_PTR,
    S_RD_OPR,
    S_WT_OPR,
    S_DONE
  } st_e;

endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
  import ea_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output am_ctl_t           ctl_o
);

  always_comb begin
    ctl_o = '0;
    case (am_e'(mode_i))
      AM_IMM:  ctl_o.src_imm = 1'b1;
      AM_REG:  ctl_o.src_imm = 1'b0;
      AM_RIND: ctl_o.use_mem = 1'b1;
      AM_RINC: begin
        ctl_o.use_mem = 1'b1;
        ctl_o.wb      = 1'b1;
      end
      AM_DIR:  ctl_o.use_mem = 1'b1;
      AM_IND: begin
        ctl_o.use_mem   = 1'b1;
        ctl_o.two_reads = 1'b1;
      end
      AM_REL:  ctl_o.use_mem = 1'b1;
      AM_IDX:  ctl_o.use_mem = 1'b1;
      default: ctl_o.implied = 1'b1;  // code 0 and unassigned codes
    endcase
  end

endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int FW = 12
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [FW-1:0]     field_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [DW-1:0]     rf_data_i,
  output logic [AW-1:0]     ea_o,
  output logic [AW-1:0]     ptr_o
);

  logic [AW-1:0] field_z;
  logic [AW-1:0] field_s;
  logic [AW-1:0] reg_a;

  assign field_z = AW'(field_i);
  assign field_s = AW'($signed(field_i));
  assign reg_a   = rf_data_i[AW-1:0];
  assign ptr_o   = field_z;

  always_comb begin
    case (am_e'(mode_i))
      AM_RIND, AM_RINC: ea_o = reg_a;
      AM_DIR:           ea_o = field_z;
      AM_REL:           ea_o = pc_i + field_s;
      AM_IDX:           ea_o = field_z + reg_a;
      default:          ea_o = '0;
    endcase
  end

endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  am_ctl_t       ctl_i,
  input  logic [AW-1:0] ea_calc_i,
  input  logic [AW-1:0] ptr_addr_i,
  input  logic [DW-1:0] imm_opnd_i,
  input  logic [DW-1:0] reg_opnd_i,
  input  logic [RW-1:0] reg_sel_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          done_o,
  output logic          implied_o,
  output logic [AW-1:0] ea_o,
  output logic [DW-1:0] operand_o,
  output logic          wb_en_o,
  output logic [RW-1:0] wb_idx_o,
  output logic [DW-1:0] wb_data_o
);

  st_e           state_q;
  logic [AW-1:0] ea_q;
  logic [DW-1:0] opnd_q;
  logic          impl_q;
  logic          wb_q;
  logic [RW-1:0] sel_q;
  logic          accept;

  assign accept = start_i && (state_q == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ea_q    <= '0;
      opnd_q  <= '0;
      impl_q  <= 1'b0;
      wb_q    <= 1'b0;
      sel_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          sel_q  <= reg_sel_i;
          impl_q <= ctl_i.implied;
          wb_q   <= ctl_i.wb;
          if (!ctl_i.use_mem) begin
            ea_q    <= '0;
            opnd_q  <= ctl_i.implied ? '0 : (ctl_i.src_imm ? imm_opnd_i : reg_opnd_i);
            state_q <= S_DONE;
          end else if (ctl_i.two_reads) begin
            ea_q    <= ptr_addr_i;  // holds pointer address until it is read
            state_q <= S_RD_PTR;
          end else begin
            ea_q    <= ea_calc_i;
            state_q <= S_RD_OPR;
          end
        end
        S_RD_PTR: state_q <= S_WT_PTR;
        S_WT_PTR: begin
          ea_q    <= mem_rdata_i[AW-1:0];
          state_q <= S_RD_OPR;
        end
        S_RD_OPR: state_q <= S_WT_OPR;
        S_WT_OPR: begin
          opnd_q  <= mem_rdata_i;
          state_q <= S_DONE;
        end
        S_DONE:   state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign mem_req_o  = (state_q == S_RD_PTR) || (state_q == S_RD_OPR);
  assign mem_addr_o = ea_q;
  assign done_o     = (state_q == S_DONE);
  assign implied_o  = impl_q;
  assign ea_o       = ea_q;
  assign operand_o  = opnd_q;
  assign wb_en_o    = done_o && wb_q;
  assign wb_idx_o   = sel_q;
  assign wb_data_o  = DW'(ea_q) + DW'(1);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R11
  AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);  // R11
  AST_READ_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);  // R7
  AST_WB_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> done_o);  // R12
  AST_IMPLIED_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !implied_o);  // R10
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);  // R11

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int  AW   = 16,
  parameter int  DW   = 16,
  parameter int  FW   = 12,
  parameter int  NREG = 8,
  localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [FW-1:0]     field_i,
  input  logic [RW-1:0]     reg_sel_i,
  input  logic [AW-1:0]     pc_i,
  output logic [RW-1:0]     rf_raddr_o,
  input  logic [DW-1:0]     rf_rdata_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              implied_o,
  output logic [AW-1:0]     ea_o,
  output logic [DW-1:0]     operand_o,
  output logic              wb_en_o,
  output logic [RW-1:0]     wb_idx_o,
  output logic [DW-1:0]     wb_data_o
);

  am_ctl_t       ctl;
  logic [AW-1:0] ea_calc;
  logic [AW-1:0] ptr_addr;
  logic [DW-1:0] imm_opnd;

  assign rf_raddr_o = reg_sel_i;
  assign imm_opnd   = DW'(field_i);

  ea_mode_dec u_dec (
    .mode_i (mode_i),
    .ctl_o  (ctl)
  );

  ea_addr_calc #(.AW(AW), .DW(DW), .FW(FW)) u_calc (
    .mode_i    (mode_i),
    .field_i   (field_i),
    .pc_i      (pc_i),
    .rf_data_i (rf_rdata_i),
    .ea_o      (ea_calc),
    .ptr_o     (ptr_addr)
  );

  ea_seq #(.AW(AW), .DW(DW), .RW(RW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .ctl_i       (ctl),
    .ea_calc_i   (ea_calc),
    .ptr_addr_i  (ptr_addr),
    .imm_opnd_i  (imm_opnd),
    .reg_opnd_i  (rf_rdata_i),
    .reg_sel_i   (reg_sel_i),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .done_o      (done_o),
    .implied_o   (implied_o),
    .ea_o        (ea_o),
    .operand_o   (operand_o),
    .wb_en_o     (wb_en_o),
    .wb_idx_o    (wb_idx_o),
    .wb_data_o   (wb_data_o)
  );

  AST_IMM_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_i == AM_IMM) |=> (done_o && !implied_o));  // R2
  AST_DIR_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_i == AM_DIR) |-> ##3 done_o);  // R6
  AST_IND_PTR_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_i == AM_IND) |=>
      (mem_req_o && mem_addr_o == AW'($past(field_i))));  // R7

endmodule

// File: tb/sim_ea_gen.sv
module sim_ea_gen;
  import ea_pkg::*;

  localparam int AW   = 16;
  localparam int DW   = 16;
  localparam int FW   = 12;
  localparam int NREG = 8;
  localparam int RW   = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [MODE_W-1:0] mode = '0;
  logic [FW-1:0]     field = '0;
  logic [RW-1:0]     sel = '0;
  logic [AW-1:0]     pc = '0;
  logic [RW-1:0]     rf_raddr;
  logic [DW-1:0]     rf_rdata;
  logic              mem_req;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_rdata = '0;
  logic              busy, done, implied, wb_en;
  logic [AW-1:0]     ea;
  logic [DW-1:0]     operand;
  logic [RW-1:0]     wb_idx;
  logic [DW-1:0]     wb_data;
  logic [DW-1:0]     rf [NREG];

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ea_gen #(.AW(AW), .DW(DW), .FW(FW), .NREG(NREG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .field_i(field), .reg_sel_i(sel), .pc_i(pc),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .implied_o(implied),
    .ea_o(ea), .operand_o(operand),
    .wb_en_o(wb_en), .wb_idx_o(wb_idx), .wb_data_o(wb_data)
  );

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    logic [31:0] p;
    p = 32'(a) * 32'h9E37;
    return DW'(p) ^ DW'(16'h5A5A);
  endfunction

  assign rf_rdata = rf[rf_raddr];

  always @(posedge clk) begin
    if (mem_req) mem_rdata <= memf(mem_addr);
    if (wb_en) rf[wb_idx] <= wb_data;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] m, input logic [FW-1:0] f, input logic [RW-1:0] s,
                     input logic [AW-1:0] p);
    logic [AW-1:0] e_ea, fz, a0, a1, got0, got1;
    logic [DW-1:0] e_op, rv;
    int e_lat, e_nreq, lat, nreq, early_wb;
    bit e_impl, e_wb;
    string tag;
    rv = rf[s];
    fz = AW'(f);
    e_ea = '0; e_op = '0; e_impl = 0; e_wb = 0; e_lat = 3; e_nreq = 1;
    a0 = '0; a1 = '0;
    case (m)
      4'd1: begin tag = "R2"; e_op = DW'(f); e_lat = 1; e_nreq = 0; end
      4'd2: begin tag = "R3"; e_op = rv; e_lat = 1; e_nreq = 0; end
      4'd3: begin tag = "R4"; e_ea = rv; end
      4'd4: begin tag = "R5"; e_ea = rv; e_wb = 1; end
      4'd5: begin tag = "R6"; e_ea = fz; end
      4'd6: begin tag = "R7"; a0 = fz; e_ea = memf(fz); e_lat = 5; e_nreq = 2; end
      4'd7: begin tag = "R8"; e_ea = p + AW'($signed(f)); end
      4'd8: begin tag = "R9"; e_ea = fz + rv; end
      default: begin tag = "R10"; e_impl = 1; e_lat = 1; e_nreq = 0; end
    endcase
    if (e_nreq > 0 && !e_impl) begin
      if (m == 4'd6) a1 = e_ea; else a0 = e_ea;
      e_op = memf(e_ea);
    end
    @(negedge clk);
    start = 1'b1; mode = m; field = f; sel = s; pc = p;
    @(negedge clk);
    start = 1'b0;
    lat = 1; nreq = 0; early_wb = 0; got0 = '0; got1 = '0;
    while (!done && lat < 12) begin
      if (mem_req) begin
        if (nreq == 0) got0 = mem_addr; else got1 = mem_addr;
        nreq++;
      end
      if (wb_en) early_wb++;
      @(negedge clk);
      lat++;
    end
    chk(lat == e_lat, {tag, " latency"}, 32'(lat), 32'(e_lat));
    chk(ea == e_ea, {tag, " ea"}, 32'(ea), 32'(e_ea));
    chk(operand == e_op, {tag, " operand"}, 32'(operand), 32'(e_op));
    chk(implied == e_impl, {tag, " R10 implied flag"}, 32'(implied), 32'(e_impl));
    chk(nreq == e_nreq, {tag, " read count"}, 32'(nreq), 32'(e_nreq));
    if (e_nreq >= 1) chk(got0 == a0, {tag, " first read addr"}, 32'(got0), 32'(a0));
    if (e_nreq == 2) chk(got1 == a1, {tag, " second read addr"}, 32'(got1), 32'(a1));
    chk(early_wb == 0 && wb_en == e_wb, {tag, " R12 wb_en"}, 32'(wb_en), 32'(e_wb));
    if (e_wb) begin
      chk(wb_idx == s, "R5 wb_idx", 32'(wb_idx), 32'(s));
      chk(wb_data == rv + DW'(1), "R5 wb_data", 32'(wb_data), 32'(rv + DW'(1)));
    end
    @(negedge clk);
    chk(!done && !wb_en && ea == e_ea, "R11 pulse/hold", {done, wb_en, 14'd0, ea}, {2'b00, 14'd0, e_ea});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NREG; i++) rf[i] = DW'($urandom);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !wb_en && !implied, "R1 reset flags",
        {busy, done, mem_req, wb_en, implied}, 32'd0);
    chk(ea == '0 && operand == '0, "R1 reset values", {ea, operand}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run(4'd1, 12'hABC, 3'd0, 16'h0);
    run(4'd2, 12'h000, 3'd5, 16'h0);
    run(4'd3, 12'h000, 3'd2, 16'h0);
    rf[6] = 16'hFFFF;
    run(4'd4, 12'h000, 3'd6, 16'h0);
    chk(rf[6] == 16'h0000, "R5 wrap write-back", 32'(rf[6]), 32'h0);
    run(4'd4, 12'h000, 3'd6, 16'h0);
    run(4'd5, 12'hFFF, 3'd0, 16'h0);
    run(4'd6, 12'h123, 3'd0, 16'h0);
    run(4'd7, 12'd500, 3'd0, 16'd252);
    chk(ea == 16'd752, "R8 example 500+252", 32'(ea), 32'd752);
    run(4'd7, 12'hFFF, 3'd0, 16'h0000);
    chk(ea == 16'hFFFF, "R8 negative wrap", 32'(ea), 32'hFFFF);
    rf[1] = 16'hFFFF;
    run(4'd8, 12'h002, 3'd1, 16'h0);
    chk(ea == 16'h0001, "R9 index wrap", 32'(ea), 32'h1);
    run(4'd0, 12'h7FF, 3'd3, 16'h1234);
    run(4'd13, 12'h7FF, 3'd3, 16'h1234);

    // R11: start held during an indirect operation and its done cycle is ignored
    @(negedge clk);
    start = 1'b1; mode = 4'd6; field = 12'h0F0; sel = 3'd0;
    @(negedge clk);
    mode = 4'd1; field = 12'h055;
    begin
      int n;
      n = 1;
      while (!done && n < 12) begin @(negedge clk); n++; end
      chk(n == 5, "R11 busy start ignored latency", 32'(n), 32'd5);
      chk(ea == memf(16'h00F0) && !implied, "R11 busy start ignored ea", 32'(ea), 32'(memf(16'h00F0)));
    end
    start = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R11 done-cycle start ignored", {busy, done}, 32'd0);
    @(negedge clk);
    chk(!busy && !done, "R11 no late start", {busy, done}, 32'd0);

    for (int i = 0; i < 120; i++) begin
      logic [3:0] m;
      m = 4'($urandom % 16);
      run(m, FW'($urandom), RW'($urandom), AW'($urandom));
      if ($urandom % 8 == 0) rf[$urandom % NREG] = DW'($urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule